// File: doc/BRIEF.md
# IPv4 Longest-Prefix Next-Hop Stage

This block is a single match-action stage in a packet pipeline. Each cycle it can take one parsed header: the IPv4 destination address, the TTL, and a flag that says whether an IPv4 header is present. It compares the destination with every entry of a small prefix table at once. The enabled entry with the longest matching prefix wins, and the stage applies that entry's action. A forward action loads the entry's next-hop address and egress port into the packet metadata and lowers the TTL by one. A drop action marks the packet for discard.

When no entry matches, the stage applies a default action that can be reprogrammed. After reset the default is drop. A packet without a valid IPv4 header is tagged as bypass and passes through without change, so that a later stage can handle it. Results appear exactly two cycles after the header, in input order.

Entries and the default action are written through a one-cycle control port. A write takes effect from the next lookup onward. A lookup in the same cycle as a write still sees the old contents.

Top module: `ipv4_lpm_stage`

## Requirements
- R1: Every accepted header (`in_valid`=1) yields exactly one result with `out_valid`=1, two clock cycles after it is sampled. Results come out in input order, and with no input there is no result.
- R2: A header with `in_ipv4_ok`=0 gives `out_bypass`=1, `out_drop`=0, `out_hit`=0, `out_nhop`=0, `out_port`=0, and `out_ttl` equal to the input TTL.
- R3: An enabled entry of length L matches when the top L bits of the destination equal the top L bits of its prefix.
  - Prefix bits below L are ignored.
  - Length 0 matches every address.
  - A length above 32 is stored as 32.
- R4: When several entries match, the longest prefix wins. Among entries of equal length, the lowest index wins.
- R5: A forward action (`cfg_drop`=0) on a packet whose input TTL is 2 or more gives the following: `out_drop`=0, the entry's next hop and port, `out_ttl` = input TTL minus 1, and `out_hit`=1 when an entry matched.
- R6: A drop action (`cfg_drop`=1) gives `out_drop`=1, `out_nhop`=0, `out_port`=0, and `out_ttl` equal to the input TTL.
- R7: A miss applies the default action and reports `out_hit`=0. After reset the default action is drop.
- R8: A write with `cfg_to_default`=1 replaces the default action, next hop and port, and ignores `cfg_index` and `cfg_enable`.
- R9: A forward decision on a packet with input TTL 0 or 1 is turned into a drop, with the same outputs as R6.
- R10: A control write issued in the same cycle as a lookup does not affect that lookup. It does affect every later lookup.
- R11: Writing an entry with `cfg_enable`=0 removes it from matching. After reset all entries are disabled.
- R12: While reset is asserted, and in every cycle without a result, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header present this cycle |
| in_ipv4_ok | input | 1 | IPv4 header valid; 0 selects bypass |
| in_dst | input | 32 | IPv4 destination address |
| in_ttl | input | 8 | IPv4 TTL |
| cfg_wr | input | 1 | Control write strobe |
| cfg_to_default | input | 1 | 1: write the default action instead of an entry |
| cfg_index | input | IDX_W | Entry index |
| cfg_enable | input | 1 | Entry takes part in matching |
| cfg_prefix | input | 32 | Entry prefix |
| cfg_len | input | 6 | Prefix length 0..32 |
| cfg_drop | input | 1 | Action: 0 forward, 1 drop |
| cfg_nhop | input | 32 | Next-hop address for forward |
| cfg_port | input | PORT_W | Egress port for forward |
| out_valid | output | 1 | Result present |
| out_bypass | output | 1 | Packet had no valid IPv4 header |
| out_drop | output | 1 | Packet marked for drop |
| out_hit | output | 1 | A table entry matched |
| out_nhop | output | 32 | Next-hop address |
| out_port | output | PORT_W | Egress port |
| out_ttl | output | 8 | Resulting TTL |

## Verification
The bound checker tests the following on every cycle:
- the two-cycle valid alignment and the bypass flag passing through;
- clean bypass and drop outputs, with no next hop, no port and the TTL unchanged;
- the TTL decrement on every forwarded packet, and the forced drop at low TTL;
- all-zero outputs when idle.

Which entry wins cannot be seen from the ports cycle by cycle, so only the bench scenarios show it. These scenarios cover nested prefixes, equal-length ties, masked prefix bits, lengths 0 and above 32, the reprogrammed default action, and a write landing in the same cycle as a lookup.

// File: rtl/lpm_stage_pkg.sv
package lpm_stage_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 6;
    localparam int TTL_W  = 8;

    // Mask that keeps the top 'len' bits of an address; lengths past ADDR_W saturate.
    function automatic logic [ADDR_W-1:0] prefix_mask(input logic [LEN_W-1:0] len);
        logic [ADDR_W-1:0] m;
        if (int'(len) >= ADDR_W) begin
            m = '1;
        end else begin
            m = ~({ADDR_W{1'b1}} >> len);
        end
        return m;
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] r;
        if (int'(len) > ADDR_W) begin
            r = LEN_W'(ADDR_W);
        end else begin
            r = len;
        end
        return r;
    endfunction

endpackage

// File: rtl/lpm_table.sv
module lpm_table
    import lpm_stage_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int PORT_W    = 4,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic                               wr_to_default,
    input  logic [IDX_W-1:0]                   wr_index,
    input  logic                               wr_enable,
    input  logic [ADDR_W-1:0]                  wr_prefix,
    input  logic [LEN_W-1:0]                   wr_len,
    input  logic                               wr_drop,
    input  logic [ADDR_W-1:0]                  wr_nhop,
    input  logic [PORT_W-1:0]                  wr_port,
    output logic [N_ENTRIES-1:0]               ent_en,
    output logic [N_ENTRIES-1:0][ADDR_W-1:0]   ent_prefix,
    output logic [N_ENTRIES-1:0][LEN_W-1:0]    ent_len,
    output logic [N_ENTRIES-1:0]               ent_drop,
    output logic [N_ENTRIES-1:0][ADDR_W-1:0]   ent_nhop,
    output logic [N_ENTRIES-1:0][PORT_W-1:0]   ent_port,
    output logic                               dflt_drop,
    output logic [ADDR_W-1:0]                  dflt_nhop,
    output logic [PORT_W-1:0]                  dflt_port
);

    typedef struct packed {
        logic               en;
        logic [ADDR_W-1:0]  prefix;
        logic [LEN_W-1:0]   len;
        logic               drop;
        logic [ADDR_W-1:0]  nhop;
        logic [PORT_W-1:0]  port;
    } slot_t;

    typedef struct packed {
        slot_t [N_ENTRIES-1:0] slot;
        logic                  dflt_drop;
        logic [ADDR_W-1:0]     dflt_nhop;
        logic [PORT_W-1:0]     dflt_port;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        logic [LEN_W-1:0] len_c;
        tbl_d = tbl_q;
        len_c = clamp_len(wr_len);
        if (wr) begin
            if (wr_to_default) begin
                tbl_d.dflt_drop = wr_drop;
                tbl_d.dflt_nhop = wr_nhop;
                tbl_d.dflt_port = wr_port;
            end else if (int'(wr_index) < N_ENTRIES) begin
                tbl_d.slot[wr_index].en     = wr_enable;
                tbl_d.slot[wr_index].prefix = wr_prefix & prefix_mask(len_c);
                tbl_d.slot[wr_index].len    = len_c;
                tbl_d.slot[wr_index].drop   = wr_drop;
                tbl_d.slot[wr_index].nhop   = wr_nhop;
                tbl_d.slot[wr_index].port   = wr_port;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q           <= '0;
            tbl_q.dflt_drop <= 1'b1;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_out
        assign ent_en[g]     = tbl_q.slot[g].en;
        assign ent_prefix[g] = tbl_q.slot[g].prefix;
        assign ent_len[g]    = tbl_q.slot[g].len;
        assign ent_drop[g]   = tbl_q.slot[g].drop;
        assign ent_nhop[g]   = tbl_q.slot[g].nhop;
        assign ent_port[g]   = tbl_q.slot[g].port;
    end

    assign dflt_drop = tbl_q.dflt_drop;
    assign dflt_nhop = tbl_q.dflt_nhop;
    assign dflt_port = tbl_q.dflt_port;

endmodule

// File: rtl/lpm_match.sv
module lpm_match
    import lpm_stage_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [ADDR_W-1:0]                 key,
    input  logic [N_ENTRIES-1:0]              ent_en,
    input  logic [N_ENTRIES-1:0][ADDR_W-1:0]  ent_prefix,
    input  logic [N_ENTRIES-1:0][LEN_W-1:0]   ent_len,
    output logic                              hit,
    output logic [IDX_W-1:0]                  win_idx
);

    logic [N_ENTRIES-1:0] cand;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign cand[g] = ent_en[g] &&
                         ((key & prefix_mask(ent_len[g])) == ent_prefix[g]);
    end

    // Strict greater-than keeps the lowest index on equal lengths.
    always_comb begin
        logic [LEN_W-1:0] best_len;
        hit      = 1'b0;
        win_idx  = '0;
        best_len = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (cand[i] && (!hit || ent_len[i] > best_len)) begin
                hit      = 1'b1;
                win_idx  = IDX_W'(i);
                best_len = ent_len[i];
            end
        end
    end

endmodule

// File: rtl/lpm_action.sv
module lpm_action
    import lpm_stage_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    input  logic               s_bypass,
    input  logic               s_hit,
    input  logic               s_drop,
    input  logic [ADDR_W-1:0]  s_nhop,
    input  logic [PORT_W-1:0]  s_port,
    input  logic [TTL_W-1:0]   s_ttl,
    output logic               out_valid,
    output logic               out_bypass,
    output logic               out_drop,
    output logic               out_hit,
    output logic [ADDR_W-1:0]  out_nhop,
    output logic [PORT_W-1:0]  out_port,
    output logic [TTL_W-1:0]   out_ttl
);

    typedef struct packed {
        logic               valid;
        logic               bypass;
        logic               drop;
        logic               hit;
        logic [ADDR_W-1:0]  nhop;
        logic [PORT_W-1:0]  port;
        logic [TTL_W-1:0]   ttl;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        logic expired;
        res_d   = '0;
        expired = (s_ttl <= TTL_W'(1));
        if (s_valid) begin
            res_d.valid = 1'b1;
            if (s_bypass) begin
                res_d.bypass = 1'b1;
                res_d.ttl    = s_ttl;
            end else begin
                res_d.hit = s_hit;
                if (s_drop || expired) begin
                    res_d.drop = 1'b1;
                    res_d.ttl  = s_ttl;
                end else begin
                    res_d.nhop = s_nhop;
                    res_d.port = s_port;
                    res_d.ttl  = s_ttl - TTL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_bypass = res_q.bypass;
    assign out_drop   = res_q.drop;
    assign out_hit    = res_q.hit;
    assign out_nhop   = res_q.nhop;
    assign out_port   = res_q.port;
    assign out_ttl    = res_q.ttl;

endmodule

// File: rtl/ipv4_lpm_stage.sv
module ipv4_lpm_stage
    import lpm_stage_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int PORT_W    = 4,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_ipv4_ok,
    input  logic [31:0]        in_dst,
    input  logic [7:0]         in_ttl,
    input  logic               cfg_wr,
    input  logic               cfg_to_default,
    input  logic [IDX_W-1:0]   cfg_index,
    input  logic               cfg_enable,
    input  logic [31:0]        cfg_prefix,
    input  logic [5:0]         cfg_len,
    input  logic               cfg_drop,
    input  logic [31:0]        cfg_nhop,
    input  logic [PORT_W-1:0]  cfg_port,
    output logic               out_valid,
    output logic               out_bypass,
    output logic               out_drop,
    output logic               out_hit,
    output logic [31:0]        out_nhop,
    output logic [PORT_W-1:0]  out_port,
    output logic [7:0]         out_ttl
);

    logic [N_ENTRIES-1:0]              ent_en;
    logic [N_ENTRIES-1:0][ADDR_W-1:0]  ent_prefix;
    logic [N_ENTRIES-1:0][LEN_W-1:0]   ent_len;
    logic [N_ENTRIES-1:0]              ent_drop;
    logic [N_ENTRIES-1:0][ADDR_W-1:0]  ent_nhop;
    logic [N_ENTRIES-1:0][PORT_W-1:0]  ent_port;
    logic                              dflt_drop;
    logic [ADDR_W-1:0]                 dflt_nhop;
    logic [PORT_W-1:0]                 dflt_port;
    logic                              m_hit;
    logic [IDX_W-1:0]                  m_idx;

    lpm_table #(.N_ENTRIES(N_ENTRIES), .PORT_W(PORT_W)) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (cfg_wr),
        .wr_to_default (cfg_to_default),
        .wr_index      (cfg_index),
        .wr_enable     (cfg_enable),
        .wr_prefix     (cfg_prefix),
        .wr_len        (cfg_len),
        .wr_drop       (cfg_drop),
        .wr_nhop       (cfg_nhop),
        .wr_port       (cfg_port),
        .ent_en        (ent_en),
        .ent_prefix    (ent_prefix),
        .ent_len       (ent_len),
        .ent_drop      (ent_drop),
        .ent_nhop      (ent_nhop),
        .ent_port      (ent_port),
        .dflt_drop     (dflt_drop),
        .dflt_nhop     (dflt_nhop),
        .dflt_port     (dflt_port)
    );

    lpm_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .key        (in_dst),
        .ent_en     (ent_en),
        .ent_prefix (ent_prefix),
        .ent_len    (ent_len),
        .hit        (m_hit),
        .win_idx    (m_idx)
    );

    // Stage 1: capture the winning action so later writes cannot reach an in-flight packet.
    typedef struct packed {
        logic               valid;
        logic               bypass;
        logic               hit;
        logic               drop;
        logic [ADDR_W-1:0]  nhop;
        logic [PORT_W-1:0]  port;
        logic [TTL_W-1:0]   ttl;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = '0;
        if (in_valid) begin
            sel_d.valid = 1'b1;
            sel_d.ttl   = in_ttl;
            if (!in_ipv4_ok) begin
                sel_d.bypass = 1'b1;
            end else if (m_hit) begin
                sel_d.hit  = 1'b1;
                sel_d.drop = ent_drop[m_idx];
                sel_d.nhop = ent_nhop[m_idx];
                sel_d.port = ent_port[m_idx];
            end else begin
                sel_d.drop = dflt_drop;
                sel_d.nhop = dflt_nhop;
                sel_d.port = dflt_port;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    lpm_action #(.PORT_W(PORT_W)) u_action (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (sel_q.valid),
        .s_bypass   (sel_q.bypass),
        .s_hit      (sel_q.hit),
        .s_drop     (sel_q.drop),
        .s_nhop     (sel_q.nhop),
        .s_port     (sel_q.port),
        .s_ttl      (sel_q.ttl),
        .out_valid  (out_valid),
        .out_bypass (out_bypass),
        .out_drop   (out_drop),
        .out_hit    (out_hit),
        .out_nhop   (out_nhop),
        .out_port   (out_port),
        .out_ttl    (out_ttl)
    );

endmodule

// File: rtl/lpm_stage_checker.sv
module lpm_stage_checker #(
    parameter int PORT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ipv4_ok,
    input logic [7:0]         in_ttl,
    input logic               out_valid,
    input logic               out_bypass,
    input logic               out_drop,
    input logic               out_hit,
    input logic [31:0]        out_nhop,
    input logic [PORT_W-1:0]  out_port,
    input logic [7:0]         out_ttl
);

    logic       v1_q, v2_q, b1_q, b2_q;
    logic [7:0] t1_q, t2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            b1_q <= 1'b0;
            b2_q <= 1'b0;
            t1_q <= '0;
            t2_q <= '0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
            b1_q <= in_valid && !in_ipv4_ok;
            b2_q <= b1_q;
            t1_q <= in_ttl;
            t2_q <= t1_q;
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2_q);

    assert_bypass_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bypass == b2_q));

    assert_bypass_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bypass) |->
            (!out_drop && !out_hit && out_nhop == '0 && out_port == '0 && out_ttl == t2_q));

    assert_ttl_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bypass && !out_drop) |-> (out_ttl == 8'(t2_q - 8'd1)));

    assert_drop_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_drop |-> (out_nhop == '0 && out_port == '0 && out_ttl == t2_q));

    assert_ttl_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bypass && t2_q <= 8'd1) |-> out_drop);

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_bypass && !out_drop && !out_hit &&
                        out_nhop == '0 && out_port == '0 && out_ttl == '0));

endmodule

bind ipv4_lpm_stage lpm_stage_checker #(.PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ipv4_ok (in_ipv4_ok),
    .in_ttl     (in_ttl),
    .out_valid  (out_valid),
    .out_bypass (out_bypass),
    .out_drop   (out_drop),
    .out_hit    (out_hit),
    .out_nhop   (out_nhop),
    .out_port   (out_port),
    .out_ttl    (out_ttl)
);

// File: tb/ipv4_lpm_stage_test.sv
module ipv4_lpm_stage_test;

    localparam int NE = 8;
    localparam int PW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_ipv4_ok = 1'b0;
    logic [31:0]   in_dst = '0;
    logic [7:0]    in_ttl = '0;
    logic          cfg_wr = 1'b0, cfg_to_default = 1'b0, cfg_enable = 1'b0, cfg_drop = 1'b0;
    logic [IW-1:0] cfg_index = '0;
    logic [31:0]   cfg_prefix = '0, cfg_nhop = '0;
    logic [5:0]    cfg_len = '0;
    logic [PW-1:0] cfg_port = '0;
    logic          out_valid, out_bypass, out_drop, out_hit;
    logic [31:0]   out_nhop;
    logic [PW-1:0] out_port;
    logic [7:0]    out_ttl;

    ipv4_lpm_stage #(.N_ENTRIES(NE), .PORT_W(PW)) uut (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic        byp;
        logic        drop;
        logic        hit;
        logic [31:0] nhop;
        logic [PW-1:0] port;
        logic [7:0]  ttl;
        string       req;
    } exp_t;

    exp_t q[$];

    task automatic tick();
        @(negedge clk);
        in_valid = 1'b0;
        cfg_wr   = 1'b0;
    endtask

    task automatic put_lookup(input logic ok, input logic [31:0] dst, input logic [7:0] ttl,
                              input logic e_byp, input logic e_drop, input logic e_hit,
                              input logic [31:0] e_nhop, input logic [PW-1:0] e_port,
                              input logic [7:0] e_ttl, input string req);
        exp_t e;
        in_valid   = 1'b1;
        in_ipv4_ok = ok;
        in_dst     = dst;
        in_ttl     = ttl;
        e.due  = cyc + 2;
        e.byp  = e_byp;
        e.drop = e_drop;
        e.hit  = e_hit;
        e.nhop = e_nhop;
        e.port = e_port;
        e.ttl  = e_ttl;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic put_cfg(input logic to_dflt, input int idx, input logic en,
                           input logic [31:0] prefix, input logic [5:0] len,
                           input logic drop, input logic [31:0] nhop, input logic [PW-1:0] port);
        cfg_wr         = 1'b1;
        cfg_to_default = to_dflt;
        cfg_index      = IW'(idx);
        cfg_enable     = en;
        cfg_prefix     = prefix;
        cfg_len        = len;
        cfg_drop       = drop;
        cfg_nhop       = nhop;
        cfg_port       = port;
    endtask

    // Convenience wrappers for the common outcomes.
    task automatic look_fwd(input logic [31:0] dst, input logic [7:0] ttl, input logic hit,
                            input logic [31:0] nh, input logic [PW-1:0] port, input string req);
        tick();
        put_lookup(1'b1, dst, ttl, 1'b0, 1'b0, hit, nh, port, ttl - 8'd1, req);
    endtask

    task automatic look_drop(input logic [31:0] dst, input logic [7:0] ttl, input logic hit,
                             input string req);
        tick();
        put_lookup(1'b1, dst, ttl, 1'b0, 1'b1, hit, '0, '0, ttl, req);
    endtask

    task automatic write_entry(input int idx, input logic en, input logic [31:0] prefix,
                               input logic [5:0] len, input logic drop,
                               input logic [31:0] nh, input logic [PW-1:0] port);
        tick();
        put_cfg(1'b0, idx, en, prefix, len, drop, nh, port);
    endtask

    // Monitor: pops expected results as the design produces them.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL R1: unexpected result at cycle %0d (actual out_valid=1, expected 0)", cyc);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    n_checks++;
                    if (e.due != cyc) begin
                        n_errors++;
                        $display("FAIL R1 (%s): result at cycle %0d, expected cycle %0d", e.req, cyc, e.due);
                    end else if (out_bypass !== e.byp || out_drop !== e.drop || out_hit !== e.hit ||
                                 out_nhop !== e.nhop || out_port !== e.port || out_ttl !== e.ttl) begin
                        n_errors++;
                        $display("FAIL %s: actual byp=%0b drop=%0b hit=%0b nhop=%h port=%0d ttl=%0d expected byp=%0b drop=%0b hit=%0b nhop=%h port=%0d ttl=%0d",
                                 e.req, out_bypass, out_drop, out_hit, out_nhop, out_port, out_ttl,
                                 e.byp, e.drop, e.hit, e.nhop, e.port, e.ttl);
                    end
                end
            end else if (q.size() > 0 && q[0].due < cyc) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                n_errors++;
                $display("FAIL R1 (%s): no result at cycle %0d, expected one at cycle %0d", e.req, cyc, e.due);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    localparam logic [31:0] NH_A = 32'hC0A80001, NH_B = 32'hC0A80002, NH_D = 32'hC0A800FE;
    localparam logic [31:0] NH_4 = 32'hC0A80004, NH_5 = 32'hC0A80005, NH_6 = 32'hC0A80006;
    localparam logic [31:0] NH_7 = 32'hC0A80008;

    initial begin
        // R12: outputs stay zero during reset, even with a header applied.
        repeat (3) @(negedge clk);
        in_valid = 1'b1; in_ipv4_ok = 1'b1; in_dst = 32'h0A000001; in_ttl = 8'd9;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_drop !== 1'b0 || out_bypass !== 1'b0 || out_hit !== 1'b0 ||
            out_nhop !== '0 || out_port !== '0 || out_ttl !== '0) begin
            n_errors++;
            $display("FAIL R12: in reset actual valid=%0b drop=%0b nhop=%h port=%0d ttl=%0d expected all 0",
                     out_valid, out_drop, out_nhop, out_port, out_ttl);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R7/R11: empty table after reset, so a miss drops by default.
        look_drop(32'h0A090909, 8'd64, 1'b0, "R7 R11 empty table miss drops");

        // Populate: 10/8 fwd, 10.1/16 fwd (prefix with junk low bits), 10.1.2/24 drop.
        write_entry(0, 1'b1, 32'h0A000000, 6'd8,  1'b0, NH_A, 4'd1);
        write_entry(1, 1'b1, 32'h0A01FFFF, 6'd16, 1'b0, NH_B, 4'd2);
        write_entry(2, 1'b1, 32'h0A010200, 6'd24, 1'b1, 32'hDEADBEEF, 4'd9);

        // Back-to-back lookups (R1 ordering).
        look_fwd (32'h0A090909, 8'd64, 1'b1, NH_A, 4'd1, "R5 R3 /8 forward");
        look_fwd (32'h0A010505, 8'd10, 1'b1, NH_B, 4'd2, "R4 R3 /16 beats /8, masked prefix");
        look_drop(32'h0A010207, 8'd33, 1'b1, "R6 R4 /24 drop wins");
        look_drop(32'h0B000001, 8'd20, 1'b0, "R7 miss takes default drop");
        tick();
        put_lookup(1'b0, 32'h0A010505, 8'd5, 1'b1, 1'b0, 1'b0, '0, '0, 8'd5, "R2 bypass unchanged");
        look_drop(32'h0A090909, 8'd1, 1'b1, "R9 ttl 1 forced drop");
        look_drop(32'h0A090909, 8'd0, 1'b1, "R9 ttl 0 forced drop");
        look_fwd (32'h0A090909, 8'd2, 1'b1, NH_A, 4'd1, "R9 R5 ttl 2 still forwards");

        // R4 tie: two equal /16 entries, lower index wins.
        write_entry(4, 1'b1, 32'h0A090000, 6'd16, 1'b0, NH_4, 4'd4);
        write_entry(5, 1'b1, 32'h0A090000, 6'd16, 1'b0, NH_5, 4'd5);
        look_fwd(32'h0A090101, 8'd50, 1'b1, NH_4, 4'd4, "R4 tie lowest index");

        // R3: length above 32 stored as 32 (exact match only).
        write_entry(6, 1'b1, 32'h0A090101, 6'd40, 1'b0, NH_6, 4'd6);
        look_fwd(32'h0A090101, 8'd50, 1'b1, NH_6, 4'd6, "R3 len 40 acts as /32 exact");
        look_fwd(32'h0A090102, 8'd50, 1'b1, NH_4, 4'd4, "R3 len 40 not matching neighbor");

        // R8: default becomes forward; index and enable ignored.
        tick();
        put_cfg(1'b1, 2, 1'b0, 32'h0, 6'd0, 1'b0, NH_D, 4'd7);
        look_fwd (32'h0B000001, 8'd20, 1'b0, NH_D, 4'd7, "R8 reprogrammed default forwards");
        look_drop(32'h0A010207, 8'd33, 1'b1, "R8 entry 2 untouched by default write");

        // R10/R11: disable entry 0 in the same cycle as a lookup that needs it.
        tick();
        put_cfg(1'b0, 0, 1'b0, 32'h0A000000, 6'd8, 1'b0, NH_A, 4'd1);
        put_lookup(1'b1, 32'h0AC80001, 8'd7, 1'b0, 1'b0, 1'b1, NH_A, 4'd1, 8'd6, "R10 same-cycle write unseen");
        look_fwd(32'h0AC80001, 8'd7, 1'b0, NH_D, 4'd7, "R10 R11 next lookup sees disabled entry");

        // R3: length 0 matches everything.
        write_entry(7, 1'b1, 32'h12345678, 6'd0, 1'b0, NH_7, 4'd8);
        look_fwd(32'h0B000001, 8'd3, 1'b1, NH_7, 4'd8, "R3 /0 matches any address");
        look_fwd(32'h0A010505, 8'd3, 1'b1, NH_B, 4'd2, "R4 /16 beats /0");

        // Drain and confirm nothing outstanding.
        repeat (6) tick();
        n_checks++;
        if (q.size() != 0) begin
            n_errors++;
            $display("FAIL R1: %0d results missing (expected 0)", q.size());
        end
        n_checks++;
        if (out_valid !== 1'b0 || out_ttl !== '0 || out_port !== '0) begin
            n_errors++;
            $display("FAIL R12: idle actual valid=%0b ttl=%0d port=%0d expected 0", out_valid, out_ttl, out_port);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule